// File: doc/BRIEF.md
# DMA Completion Response Port

This block sits beside a DMA data mover and keeps one record per finished descriptor: how many bytes were really moved, plus a status word. A transfer can stop before its programmed length, on end of packet, so the byte count is whatever the mover reports and may be shorter than the length that was asked for. Records arrive on a valid/ready input. They are held in an in-order queue of `DEPTH` entries, and the input is held off while the queue is full.

Software reaches the queue through a small read window. It first polls the occupancy word and goes on only when the count is non-zero. It then reads the byte count of the oldest record, and after that the status word of the same record. Reading the status word removes that record. Reading the byte count leaves the queue as it is. The occupancy and the empty and full flags also come out as plain outputs, so a status register nearby can use them.

Top module: `cplrsp_port`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_level` is 0, `rsp_empty` is 1, `rsp_full` is 0 and `cpl_ready` is 1.
- R2: A record is accepted on each clock edge where `cpl_valid` and `cpl_ready` are both high. Without a pop in that cycle, `rsp_level` rises by one.
- R3: When `rsp_level` equals `DEPTH`, `cpl_ready` is low. A record offered then is dropped: the level stays at `DEPTH` and the queued contents are unchanged.
- R4: With `rd_en` high and `rd_addr` = 0, `rd_data` is the byte count of the oldest record. The queue does not change.
- R5: With `rd_en` high and `rd_addr` = 1 on a non-empty queue, `rd_data` is the status word of the oldest record: bits 7:0 hold the error code, bit 8 holds the early-termination flag, and bits 31:9 are zero. That record is removed at the clock edge.
- R6: With `rd_en` high and `rd_addr` = 2, `rd_data` is the fill-level word: the number of queued records in bits 15:0, with bits 31:16 zero.
- R7: A read at `rd_addr` 0 or 1 while the queue is empty returns 0 and leaves the level at 0.
- R8: If a record is accepted and a status read pops in the same cycle, `rsp_level` stays the same.
- R9: Records come out in the order they were accepted.
- R10: `rsp_empty` is high exactly when `rsp_level` is 0. `rsp_full` is high exactly when `rsp_level` equals `DEPTH`.
- R11: `rd_addr` = 3, or `rd_en` low, returns 0 on `rd_data` and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpl_valid | input | 1 | A completion record is offered |
| cpl_ready | output | 1 | The queue can take a record |
| cpl_bytes | input | 32 | Bytes actually transferred |
| cpl_err | input | 8 | Error code of the transfer |
| cpl_early | input | 1 | The transfer ended before its programmed length |
| rd_en | input | 1 | Read strobe for the window |
| rd_addr | input | 2 | Word select: 0 bytes, 1 status (pops), 2 fill level, 3 reserved |
| rd_data | output | 32 | Read data, combinational from rd_en and rd_addr |
| rsp_empty | output | 1 | Queue empty |
| rsp_full | output | 1 | Queue full |
| rsp_level | output | 16 | Number of queued records |

## Verification
The hardest case to reach is a record accepted and a record popped in the same cycle. The bench makes it happen at every fill level from 0 to `DEPTH`. At the top of that range, `cpl_ready` is already low, so only the pop takes effect. At the bottom, the queue is empty, so only the push takes effect. To get there, the bench first fills the queue to each level with records whose count, error code and early flag are worked out from an index. It then raises `cpl_valid` and a status read in the same cycle and compares the popped word and the new level with its own queue model. Last, it drains the queue and checks that the order is kept.

// File: rtl/cplrsp_pkg.sv
package cplrsp_pkg;

    localparam int BYTES_W   = 32;
    localparam int ERR_W     = 8;
    localparam int WORD_W    = 32;
    localparam int LVL_W     = 16;
    localparam int EARLY_BIT = ERR_W;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic               early;
        logic [ERR_W-1:0]   err;
        logic [BYTES_W-1:0] bytes;
    } cpl_rec_t;

    typedef enum logic [1:0] {
        WIN_BYTES  = 2'd0,
        WIN_STATUS = 2'd1,
        WIN_LEVEL  = 2'd2,
        WIN_RSVD   = 2'd3
    } win_sel_e;

    function automatic word_t status_word(input cpl_rec_t rec);
        word_t w;
        w = '0;
        w[ERR_W-1:0] = rec.err;
        w[EARLY_BIT] = rec.early;
        return w;
    endfunction

endpackage

// File: rtl/cplrsp_fifo.sv
module cplrsp_fifo
    import cplrsp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  cpl_rec_t push_rec,
    input  logic     pop,
    output cpl_rec_t head,
    output lvl_t     level,
    output logic     empty,
    output logic     full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    cpl_rec_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;
    logic            do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CMAX);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign level   = lvl_t'(count);

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/cplrsp_window.sv
module cplrsp_window
    import cplrsp_pkg::*;
(
    input  logic       rd_en,
    input  logic [1:0] rd_addr,
    input  cpl_rec_t   head,
    input  logic       empty,
    input  lvl_t       level,
    output word_t      rd_data,
    output logic       pop_req
);
    win_sel_e sel;

    assign sel     = win_sel_e'(rd_addr);
    assign pop_req = rd_en && (sel == WIN_STATUS) && !empty;

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (sel)
                WIN_BYTES:  rd_data = empty ? '0 : word_t'(head.bytes);
                WIN_STATUS: rd_data = empty ? '0 : status_word(head);
                WIN_LEVEL:  rd_data = word_t'(level);
                default:    rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/cplrsp_port.sv
module cplrsp_port
    import cplrsp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpl_valid,
    output logic        cpl_ready,
    input  logic [31:0] cpl_bytes,
    input  logic [7:0]  cpl_err,
    input  logic        cpl_early,
    input  logic        rd_en,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        rsp_empty,
    output logic        rsp_full,
    output logic [15:0] rsp_level
);
    cpl_rec_t in_rec, head;
    logic     pop_req, full_w, empty_w;
    lvl_t     level_w;

    assign in_rec = '{early: cpl_early, err: cpl_err, bytes: cpl_bytes};

    cplrsp_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (cpl_valid),
        .push_rec (in_rec),
        .pop      (pop_req),
        .head     (head),
        .level    (level_w),
        .empty    (empty_w),
        .full     (full_w)
    );

    cplrsp_window u_win (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .head    (head),
        .empty   (empty_w),
        .level   (level_w),
        .rd_data (rd_data),
        .pop_req (pop_req)
    );

    assign cpl_ready = !full_w;
    assign rsp_empty = empty_w;
    assign rsp_full  = full_w;
    assign rsp_level = level_w;

endmodule

// File: rtl/cplrsp_port_chk.sv
module cplrsp_port_chk #(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        cpl_valid,
    input logic        cpl_ready,
    input logic        rd_en,
    input logic [1:0]  rd_addr,
    input logic [31:0] rd_data,
    input logic        rsp_empty,
    input logic        rsp_full,
    input logic [15:0] rsp_level
);
    logic acc, popping;
    assign acc     = cpl_valid && cpl_ready;
    assign popping = rd_en && (rd_addr == 2'd1) && !rsp_empty;

    p_ready_low_full_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_level == 16'(DEPTH)) |-> !cpl_ready);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_level <= 16'(DEPTH));

    p_push_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (acc && !popping) |=> rsp_level == $past(rsp_level) + 16'd1);

    p_pop_dec_r5: assert property (@(posedge clk) disable iff (rst)
        (popping && !acc) |=> rsp_level == $past(rsp_level) - 16'd1);

    p_push_pop_r8: assert property (@(posedge clk) disable iff (rst)
        (acc && popping) |=> $stable(rsp_level));

    p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rsp_empty && !rd_addr[1]) |-> rd_data == 32'd0);

    p_fill_word_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == 2'd2) |-> rd_data == {16'd0, rsp_level});

    p_flags_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_empty == (rsp_level == 16'd0)) && (rsp_full == (rsp_level == 16'(DEPTH))));

    p_idle_read_r11: assert property (@(posedge clk) disable iff (rst)
        (!rd_en || rd_addr == 2'd3) |-> rd_data == 32'd0);

endmodule

bind cplrsp_port cplrsp_port_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpl_valid (cpl_valid),
    .cpl_ready (cpl_ready),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rsp_empty (rsp_empty),
    .rsp_full  (rsp_full),
    .rsp_level (rsp_level)
);

// File: tb/cplrsp_port_test.sv
`timescale 1ns/1ps
module cplrsp_port_test;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpl_valid, cpl_ready, cpl_early, rd_en;
    logic [31:0] cpl_bytes, rd_data;
    logic [7:0]  cpl_err;
    logic [1:0]  rd_addr;
    logic        rsp_empty, rsp_full;
    logic [15:0] rsp_level;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    int mq [0:1023];
    int mh = 0;
    int mt = 0;
    int seq = 0;

    always #2 clk = ~clk;

    cplrsp_port #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
        .cpl_bytes(cpl_bytes), .cpl_err(cpl_err), .cpl_early(cpl_early),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rsp_empty(rsp_empty), .rsp_full(rsp_full), .rsp_level(rsp_level)
    );

    function automatic logic [31:0] exp_bytes(int k);
        return 32'h0000_0040 + 32'(k) * 32'h0001_0203;
    endfunction

    function automatic logic [7:0] exp_err(int k);
        return 8'((k * 29 + 3) & 255);
    endfunction

    function automatic logic exp_early(int k);
        return 1'(k & 1);
    endfunction

    function automatic logic [31:0] exp_stat(int k);
        return {23'd0, exp_early(k), exp_err(k)};
    endfunction

    function automatic int mcount();
        return mt - mh;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle_check();
        @(negedge clk);
        cpl_valid = 1'b0; rd_en = 1'b0; rd_addr = 2'd0;
        #1;
        check("R2/R5 level", 32'(rsp_level), 32'(mcount()));
        check("R10 empty", 32'(rsp_empty), 32'(mcount() == 0));
        check("R10 full", 32'(rsp_full), 32'(mcount() == DEPTH));
        check("R11 idle data", rd_data, 32'd0);
    endtask

    task automatic push_one();
        int k;
        k = seq; seq++;
        @(negedge clk);
        cpl_valid = 1'b1; rd_en = 1'b0;
        cpl_bytes = exp_bytes(k); cpl_err = exp_err(k); cpl_early = exp_early(k);
        #1;
        check("R3 ready", 32'(cpl_ready), 32'(mcount() < DEPTH));
        if (mcount() < DEPTH) begin mq[mt] = k; mt++; end
        idle_check();
    endtask

    task automatic pop_one();
        @(negedge clk);
        cpl_valid = 1'b0; rd_en = 1'b1; rd_addr = 2'd0;
        #1;
        check("R4/R7 bytes", rd_data, mcount() > 0 ? exp_bytes(mq[mh]) : 32'd0);
        @(negedge clk);
        rd_addr = 2'd1;
        #1;
        check("R4 no pop", 32'(rsp_level), 32'(mcount()));
        check("R5/R9 status", rd_data, mcount() > 0 ? exp_stat(mq[mh]) : 32'd0);
        if (mcount() > 0) mh++;
        idle_check();
    endtask

    task automatic push_pop_one();
        int k;
        k = seq; seq++;
        @(negedge clk);
        cpl_valid = 1'b1; rd_en = 1'b1; rd_addr = 2'd1;
        cpl_bytes = exp_bytes(k); cpl_err = exp_err(k); cpl_early = exp_early(k);
        #1;
        check("R8 status", rd_data, mcount() > 0 ? exp_stat(mq[mh]) : 32'd0);
        begin
            bit can_push;
            can_push = (mcount() < DEPTH);
            if (mcount() > 0) mh++;
            if (can_push) begin mq[mt] = k; mt++; end
        end
        idle_check();
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cpl_valid = 1'b0; rd_en = 1'b0; rd_addr = 2'd0;
        cpl_bytes = '0; cpl_err = '0; cpl_early = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 level", 32'(rsp_level), 32'd0);
        check("R1 empty", 32'(rsp_empty), 32'd1);
        check("R1 full", 32'(rsp_full), 32'd0);
        check("R1 ready", 32'(cpl_ready), 32'd1);
        rst = 1'b0;
        idle_check();

        // R7: empty reads return zero and change nothing
        pop_one();

        // R3: fill past capacity; the extra offer is dropped
        for (int i = 0; i < DEPTH + 2; i++) push_one();
        check("R3 full flag", 32'(rsp_full), 32'd1);
        // R6 fill-level word at full
        @(negedge clk); rd_en = 1'b1; rd_addr = 2'd2; #1;
        check("R6 level word", rd_data, 32'(DEPTH));
        // R11 reserved word does not pop
        @(negedge clk); rd_addr = 2'd3; #1;
        check("R11 reserved", rd_data, 32'd0);
        idle_check();
        // R4 repeated byte reads do not pop
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rd_en = 1'b1; rd_addr = 2'd0; #1;
            check("R4 repeat", rd_data, exp_bytes(mq[mh]));
        end
        idle_check();
        // R9 drain in order
        while (mcount() > 0) pop_one();
        pop_one();

        // R8 sweep: push and pop together at every level 0..DEPTH
        for (int lv = 0; lv <= DEPTH; lv++) begin
            for (int j = 0; j < lv; j++) push_one();
            @(negedge clk); rd_en = 1'b1; rd_addr = 2'd2; #1;
            check("R6 sweep level word", rd_data, 32'(lv));
            push_pop_one();
            while (mcount() > 0) pop_one();
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule